// File: doc/BRIEF.md
# Message Interrupt Window Decoder and Vector Steering Table

This block sits behind the inbound request path of a PCIe root port. Each memory write that reaches it comes with a type code, a 64-bit address and the low 16 bits of its payload. The block decides whether the write is a message-signalled interrupt. A 32-bit message must fall in a 64 KiB window below 4 GiB. A 64-bit message must fall in a 64 KiB window anywhere in the address space. For a message, the payload supplies a vector number, and that number selects one entry of a steering table.

Each table entry holds three things: an enable, a pending latch and the number of the event queue that should receive the interrupt. A vector that is enabled and not pending is forwarded as a queue-write request, and its pending latch is set at the same time. That vector stays silent until software acknowledges it through a per-vector acknowledge register. A message that cannot be forwarded is discarded and recorded in a sticky drop flag.

Software programs the two windows, the table and the acknowledge registers through a flat word-addressed register port. Reads of that port are combinational.

Top module: `msi_route_top`

## Requirements
- R1: A request with type code 0xB is a 32-bit message when address bits 63:32 are zero and address bits 31:16 equal bits 31:16 of the 32-bit window register (offset 0x4000).
- R2: A request with type code 0xF is a 64-bit message when address bits 63:16 equal bits 63:16 of the 64-bit window register (offset 0x4008).
- R3: A request that is not a message is ignored. This covers any other type code (0x6 included) and any window miss. It raises no queue write, leaves the drop flag alone and changes no table entry.
- R4: The vector number is payload bits 15:0. A forwarded message raises qw_valid for exactly one cycle, one clock after the request is sampled, with qw_vec equal to the vector number and qw_queue equal to the entry's queue number.
- R5: A message is forwarded only when its entry is enabled and not pending. The entry's pending latch is set on the same clock edge.
- R6: A message is dropped and drop_flag is set when its entry is disabled, already pending, or its vector number is at or above NUM_VEC. drop_flag stays set until a status write (offset 0x4010) with bit 0 set. A drop in the same cycle keeps it set.
- R7: The acknowledge register of vector n is at offset 0x2000 + 8n. A write there with bit 62 set clears that vector's pending latch. With bit 62 clear the write has no effect.
- R8: The table entry of vector n is at offset 0x0000 + 8n. A write there loads the enable from bit 63 and the queue number from bits 5:0. It never changes the pending latch. A read returns the enable at bit 63, pending at bit 62 and the queue at bits 5:0, with all other bits zero.
- R9: When a forwarded message and an acknowledge of the same vector land in the same cycle, the pending latch ends set.
- R10: After reset every entry is disabled, not pending and steered to queue 0. Both windows read zero, qw_valid is low and drop_flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Inbound write request present this cycle |
| req_type | input | 4 | Request type code |
| req_addr | input | 64 | Request address |
| req_data | input | 16 | Low 16 bits of request payload |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Combinational read data for reg_addr |
| qw_valid | output | 1 | Queue-write request, one-cycle pulse |
| qw_queue | output | 6 | Target event queue number |
| qw_vec | output | 16 | Vector number being delivered |
| drop_flag | output | 1 | Sticky record of a discarded message |

## Verification
The assertions assume that the request inputs are sampled only when req_valid is high. They also assume that req_valid and reg_wr are held low while reset is asserted, because several properties look one cycle into the past from the first edge after reset. The stimulus drives every input at the falling clock edge. It keeps req_valid low during reset and raises it for single-cycle pulses only. Each table entry and window is programmed before any message aimed at it is sent.

// File: rtl/msi_route_pkg.sv
package msi_route_pkg;

  localparam logic [3:0] TYPE_MSG32 = 4'hB;
  localparam logic [3:0] TYPE_MSG64 = 4'hF;

  localparam int QUEUE_W = 6;

  // Register regions selected by offset bits 15:13
  localparam logic [2:0] RGN_MAP = 3'd0;
  localparam logic [2:0] RGN_ACK = 3'd1;
  localparam logic [2:0] RGN_CFG = 3'd2;

  // Word selects inside the configuration region (offset bits 12:3)
  localparam logic [9:0] CFG_WIN32  = 10'd0;
  localparam logic [9:0] CFG_WIN64  = 10'd1;
  localparam logic [9:0] CFG_STATUS = 10'd2;

  localparam int BIT_ENABLE  = 63;
  localparam int BIT_PENDING = 62;

  typedef struct packed {
    logic               enable;
    logic               pending;
    logic [QUEUE_W-1:0] queue;
  } steer_ent_t;

endpackage

// File: rtl/msi_addr_match.sv
module msi_addr_match
  import msi_route_pkg::*;
(
  input  logic [3:0]  req_type,
  input  logic [63:0] req_addr,
  input  logic [15:0] win32_base,
  input  logic [47:0] win64_base,
  output logic        is_msg
);

  logic hit32;
  logic hit64;

  always_comb begin
    hit32 = (req_type == TYPE_MSG32) &&
            (req_addr[63:32] == 32'd0) &&
            (req_addr[31:16] == win32_base);
    hit64 = (req_type == TYPE_MSG64) &&
            (req_addr[63:16] == win64_base);
    is_msg = hit32 | hit64;
  end

endmodule

// File: rtl/msi_vec_table.sv
module msi_vec_table
  import msi_route_pkg::*;
#(
  parameter int NUM_VEC = 64,
  localparam int IDX_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
)(
  input  logic               clk,
  input  logic               rst_n,
  // software side
  input  logic               map_we,
  input  logic               ack_we,
  input  logic [IDX_W-1:0]   sw_idx,
  input  logic               sw_enable,
  input  logic               sw_ack,
  input  logic [QUEUE_W-1:0] sw_queue,
  output steer_ent_t         sw_entry,
  // delivery side
  input  logic [IDX_W-1:0]   lk_idx,
  input  logic               deliver,
  output steer_ent_t         lk_entry
);

  steer_ent_t ent_q [NUM_VEC];

  for (genvar gi = 0; gi < NUM_VEC; gi++) begin : g_ent
    steer_ent_t ent_d;
    logic       sw_sel;
    logic       lk_sel;

    always_comb begin
      sw_sel = (sw_idx == IDX_W'(gi));
      lk_sel = (lk_idx == IDX_W'(gi));
      ent_d  = ent_q[gi];
      if (map_we && sw_sel) begin
        ent_d.enable = sw_enable;
        ent_d.queue  = sw_queue;
      end
      // delivery takes priority over an acknowledge in the same cycle
      if (deliver && lk_sel) begin
        ent_d.pending = 1'b1;
      end else if (ack_we && sw_sel && sw_ack) begin
        ent_d.pending = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[gi] <= '0;
      end else begin
        ent_q[gi] <= ent_d;
      end
    end
  end

  always_comb begin
    sw_entry = ent_q[sw_idx];
    lk_entry = ent_q[lk_idx];
  end

endmodule

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
  import msi_route_pkg::*;
#(
  parameter int NUM_VEC = 64,
  localparam int IDX_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [15:0]        reg_addr,
  input  logic [63:0]        reg_wdata,
  input  steer_ent_t         rd_entry,
  input  logic               drop_evt,
  output logic [63:0]        reg_rdata,
  output logic [15:0]        win32_base,
  output logic [47:0]        win64_base,
  output logic               map_we,
  output logic               ack_we,
  output logic [IDX_W-1:0]   sw_idx,
  output logic               drop_flag
);

  logic [2:0]  rgn;
  logic [9:0]  slot;
  logic        slot_ok;
  logic        win32_we;
  logic        win64_we;
  logic        stat_we;
  logic [15:0] win32_d;
  logic [47:0] win64_d;
  logic        drop_d;
  logic        unused_bits;

  always_comb begin
    rgn     = reg_addr[15:13];
    slot    = reg_addr[12:3];
    slot_ok = ({22'd0, slot} < NUM_VEC);
    sw_idx  = slot[IDX_W-1:0];

    map_we   = reg_wr && (rgn == RGN_MAP) && slot_ok;
    ack_we   = reg_wr && (rgn == RGN_ACK) && slot_ok;
    win32_we = reg_wr && (rgn == RGN_CFG) && (slot == CFG_WIN32);
    win64_we = reg_wr && (rgn == RGN_CFG) && (slot == CFG_WIN64);
    stat_we  = reg_wr && (rgn == RGN_CFG) && (slot == CFG_STATUS);

    win32_d = win32_we ? reg_wdata[31:16] : win32_base;
    win64_d = win64_we ? reg_wdata[63:16] : win64_base;

    // a new drop wins over a clear in the same cycle
    if (drop_evt) begin
      drop_d = 1'b1;
    end else if (stat_we && reg_wdata[0]) begin
      drop_d = 1'b0;
    end else begin
      drop_d = drop_flag;
    end

    reg_rdata = '0;
    unique case (rgn)
      RGN_MAP: begin
        if (slot_ok) begin
          reg_rdata[BIT_ENABLE]    = rd_entry.enable;
          reg_rdata[BIT_PENDING]   = rd_entry.pending;
          reg_rdata[QUEUE_W-1:0]   = rd_entry.queue;
        end
      end
      RGN_CFG: begin
        if (slot == CFG_WIN32)  reg_rdata[31:16] = win32_base;
        if (slot == CFG_WIN64)  reg_rdata[63:16] = win64_base;
        if (slot == CFG_STATUS) reg_rdata[0]     = drop_flag;
      end
      default: reg_rdata = '0;
    endcase

    unused_bits = ^reg_addr[2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win32_base <= '0;
      win64_base <= '0;
      drop_flag  <= 1'b0;
    end else begin
      win32_base <= win32_d;
      win64_base <= win64_d;
      drop_flag  <= drop_d;
    end
  end

endmodule

// File: rtl/msi_route_top.sv
module msi_route_top
  import msi_route_pkg::*;
#(
  parameter int NUM_VEC = 64
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [3:0]         req_type,
  input  logic [63:0]        req_addr,
  input  logic [15:0]        req_data,
  input  logic               reg_wr,
  input  logic [15:0]        reg_addr,
  input  logic [63:0]        reg_wdata,
  output logic [63:0]        reg_rdata,
  output logic               qw_valid,
  output logic [QUEUE_W-1:0] qw_queue,
  output logic [15:0]        qw_vec,
  output logic               drop_flag
);

  localparam int IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  logic [15:0]        win32_base;
  logic [47:0]        win64_base;
  logic               map_we;
  logic               ack_we;
  logic [IDX_W-1:0]   sw_idx;
  steer_ent_t         sw_entry;
  steer_ent_t         lk_entry;
  logic               is_msg;
  logic               in_range;
  logic               deliver;
  logic               drop_evt;
  logic [IDX_W-1:0]   lk_idx;

  logic               qw_valid_d;
  logic [QUEUE_W-1:0] qw_queue_d;
  logic [15:0]        qw_vec_d;
  logic               qw_load;

  msi_addr_match u_match (
    .req_type   (req_type),
    .req_addr   (req_addr),
    .win32_base (win32_base),
    .win64_base (win64_base),
    .is_msg     (is_msg)
  );

  msi_cfg_regs #(.NUM_VEC(NUM_VEC)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .rd_entry   (sw_entry),
    .drop_evt   (drop_evt),
    .reg_rdata  (reg_rdata),
    .win32_base (win32_base),
    .win64_base (win64_base),
    .map_we     (map_we),
    .ack_we     (ack_we),
    .sw_idx     (sw_idx),
    .drop_flag  (drop_flag)
  );

  msi_vec_table #(.NUM_VEC(NUM_VEC)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .map_we    (map_we),
    .ack_we    (ack_we),
    .sw_idx    (sw_idx),
    .sw_enable (reg_wdata[BIT_ENABLE]),
    .sw_ack    (reg_wdata[BIT_PENDING]),
    .sw_queue  (reg_wdata[QUEUE_W-1:0]),
    .sw_entry  (sw_entry),
    .lk_idx    (lk_idx),
    .deliver   (deliver),
    .lk_entry  (lk_entry)
  );

  always_comb begin
    in_range = ({16'd0, req_data} < NUM_VEC);
    lk_idx   = req_data[IDX_W-1:0];
    deliver  = req_valid && is_msg && in_range &&
               lk_entry.enable && !lk_entry.pending;
    drop_evt = req_valid && is_msg && !deliver;

    qw_valid_d = deliver;
    qw_load    = deliver;
    qw_queue_d = qw_load ? lk_entry.queue : qw_queue;
    qw_vec_d   = qw_load ? req_data       : qw_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qw_valid <= 1'b0;
      qw_queue <= '0;
      qw_vec   <= '0;
    end else begin
      qw_valid <= qw_valid_d;
      qw_queue <= qw_queue_d;
      qw_vec   <= qw_vec_d;
    end
  end

endmodule

// File: rtl/msi_route_chk.sv
module msi_route_chk
  import msi_route_pkg::*;
#(
  parameter int NUM_VEC = 64
)(
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [3:0]  req_type,
  input logic [15:0] req_data,
  input logic        reg_wr,
  input logic [15:0] reg_addr,
  input logic [63:0] reg_wdata,
  input logic        qw_valid,
  input logic [15:0] qw_vec,
  input logic        drop_flag,
  input logic        drop_evt
);

  AST_QW_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    qw_valid |-> $past(req_valid));  // R4

  AST_QW_VEC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    qw_valid |-> (qw_vec == $past(req_data)));  // R4

  AST_QW_MSG_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    qw_valid |-> ($past(req_type) == TYPE_MSG32 || $past(req_type) == TYPE_MSG64));  // R3

  AST_QW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    qw_valid |-> ({16'd0, qw_vec} < NUM_VEC));  // R6

  AST_DROP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> drop_flag);  // R6

  AST_DROP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_flag && !(reg_wr && reg_addr == 16'h4010 && reg_wdata[0])) |=> drop_flag);  // R6

  AST_NO_DELIVER_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> !qw_valid);  // R5

endmodule

bind msi_route_top msi_route_chk #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_type  (req_type),
  .req_data  (req_data),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .qw_valid  (qw_valid),
  .qw_vec    (qw_vec),
  .drop_flag (drop_flag),
  .drop_evt  (drop_evt)
);

// File: tb/msi_route_top_bench.sv
module msi_route_top_bench;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [3:0]  req_type;
  logic [63:0] req_addr;
  logic [15:0] req_data;
  logic        reg_wr;
  logic [15:0] reg_addr;
  logic [63:0] reg_wdata;
  logic [63:0] reg_rdata;
  logic        qw_valid;
  logic [5:0]  qw_queue;
  logic [15:0] qw_vec;
  logic        drop_flag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  msi_route_top u_msi_route_top (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_type(req_type), .req_addr(req_addr), .req_data(req_data),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .qw_valid(qw_valid), .qw_queue(qw_queue), .qw_vec(qw_vec), .drop_flag(drop_flag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  localparam logic [63:0] A32 = 64'h0000_0000_1234_0000;
  localparam logic [63:0] A64 = 64'hABCD_0000_5678_0010;

  // type, addr, data, exp qw_valid, exp queue, exp drop
  localparam logic [91:0] VEC [10] = '{
    {4'hB, A32,                   16'd3,   1'b1, 6'd5,    1'b0},  // R1 R4 R5
    {4'hB, A32,                   16'd3,   1'b0, 6'd0,    1'b1},  // R6 pending
    {4'hF, A64,                   16'd10,  1'b1, 6'h21,   1'b0},  // R2 R4
    {4'hB, 64'h0000_0000_1235_0000, 16'd10, 1'b0, 6'd0,   1'b0},  // R3 miss
    {4'h6, A32,                   16'd3,   1'b0, 6'd0,    1'b0},  // R3 type
    {4'hB, A32,                   16'd7,   1'b0, 6'd0,    1'b1},  // R6 disabled
    {4'hF, A64,                   16'd100, 1'b0, 6'd0,    1'b1},  // R6 range
    {4'hB, 64'h0000_0001_1234_0000, 16'd3, 1'b0, 6'd0,    1'b0},  // R1 upper bits
    {4'hF, A64,                   16'h43,  1'b0, 6'd0,    1'b1},  // R6 range
    {4'hB, A32,                   16'd10,  1'b0, 6'd0,    1'b1}   // R6 pending
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [63:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic send(input logic [3:0] t, input logic [63:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_type = t; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<20000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] d;
    rst_n = 1'b0; req_valid = 1'b0; req_type = '0; req_addr = '0; req_data = '0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check("R10 qw_valid", {63'd0, qw_valid}, 64'd0);
    check("R10 drop_flag", {63'd0, drop_flag}, 64'd0);
    rd(16'h0018, d); check("R10 entry3", d, 64'd0);
    rd(16'h4000, d); check("R10 win32", d, 64'd0);
    rd(16'h4008, d); check("R10 win64", d, 64'd0);

    wr(16'h4000, 64'h0000_0000_1234_0000);
    wr(16'h4008, 64'hABCD_0000_5678_0000);
    wr(16'h0018, 64'h8000_0000_0000_0005);   // vec 3 -> q5
    wr(16'h0050, 64'h8000_0000_0000_0021);   // vec 10 -> q0x21
    wr(16'h0038, 64'h0000_0000_0000_0009);   // vec 7 disabled
    rd(16'h0018, d); check("R8 readback", d, 64'h8000_0000_0000_0005);

    for (int i = 0; i < 10; i++) begin
      send(VEC[i][91:88], VEC[i][87:24], VEC[i][23:8]);
      check($sformatf("R4 vec%0d qw_valid", i), {63'd0, qw_valid}, {63'd0, VEC[i][7]});
      if (VEC[i][7]) begin
        check($sformatf("R4 vec%0d queue", i), {58'd0, qw_queue}, {58'd0, VEC[i][6:1]});
        check($sformatf("R4 vec%0d num", i), {48'd0, qw_vec}, {48'd0, VEC[i][23:8]});
      end
      check($sformatf("R6 vec%0d drop", i), {63'd0, drop_flag}, {63'd0, VEC[i][0]});
      @(negedge clk);
      check($sformatf("R4 vec%0d pulse", i), {63'd0, qw_valid}, 64'd0);
      wr(16'h4010, 64'd1);
      check($sformatf("R6 vec%0d clear", i), {63'd0, drop_flag}, 64'd0);
    end

    // R5 pending visible on readback
    rd(16'h0018, d); check("R5 pending set", d, 64'hC000_0000_0000_0005);
    // R7 ack without bit 62 has no effect
    wr(16'h2050, 64'h8000_0000_0000_0000);
    rd(16'h0050, d); check("R7 ack no bit", d, 64'hC000_0000_0000_0021);
    // R8 map write keeps pending
    wr(16'h0050, 64'h8000_0000_0000_003F);
    rd(16'h0050, d); check("R8 pending kept", d, 64'hC000_0000_0000_003F);
    // R7 ack clears, then redelivery to new queue
    wr(16'h2050, 64'h4000_0000_0000_0000);
    rd(16'h0050, d); check("R7 ack clears", d, 64'h8000_0000_0000_003F);
    send(4'hF, A64, 16'd10);
    check("R7 redeliver", {63'd0, qw_valid}, 64'd1);
    check("R8 new queue", {58'd0, qw_queue}, 64'h3F);

    // R9 delivery and ack of same vector in one cycle
    wr(16'h2018, 64'h4000_0000_0000_0000);
    @(negedge clk);
    req_valid = 1'b1; req_type = 4'hB; req_addr = A32; req_data = 16'd3;
    reg_wr = 1'b1; reg_addr = 16'h2018; reg_wdata = 64'h4000_0000_0000_0000;
    @(negedge clk);
    req_valid = 1'b0; reg_wr = 1'b0;
    check("R9 delivered", {63'd0, qw_valid}, 64'd1);
    rd(16'h0018, d); check("R9 pending stays", d, 64'hC000_0000_0000_0005);

    // R6 drop and status clear in same cycle: drop wins
    @(negedge clk);
    req_valid = 1'b1; req_type = 4'hB; req_addr = A32; req_data = 16'd7;
    reg_wr = 1'b1; reg_addr = 16'h4010; reg_wdata = 64'd1;
    @(negedge clk);
    req_valid = 1'b0; reg_wr = 1'b0;
    check("R6 drop wins", {63'd0, drop_flag}, 64'd1);
    rd(16'h4010, d); check("R6 status read", d, 64'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule